// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block keeps the stack pointer of a small processor core. The pointer points at the next free byte. The stack grows toward lower addresses. Four command strobes move the pointer:

- a single-byte push and a single-byte pop;
- a two-byte push and a two-byte pop, which save or restore a return address on calls, interrupt entry and returns.

For every stack access the block gives the memory address to use, the direction of the transfer, and the value the pointer will hold after the next clock edge. It does not move the data itself.

Software sees the pointer as two 8-bit I/O registers, one for the low byte and one for the high byte. Either byte can be loaded through a write port. The parameter `SP_BITS` sets how many pointer bits exist. Bits above that width read as zero. When `SP_BITS` is 8 or less, the high register does not exist at all.

All command and I/O pins are plain level signals sampled on each rising clock edge. There is no valid/ready handshake. The core must not issue a new command while `busy_o` is high, because such a command is dropped. A two-byte command occupies two consecutive cycles, and each cycle presents one byte address.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, both I/O read ports read 0x00, `sp_next_o` is 0, `busy_o` is 0 and `mem_valid_o` is 0.
- R2: A single-byte push drives `mem_valid_o`=1, `mem_write_o`=1 and `mem_addr_o`=SP in the same cycle. After the edge, SP is SP-1.
- R3: A single-byte pop drives `mem_valid_o`=1, `mem_write_o`=0 and `mem_addr_o`=SP+1 in the same cycle. After the edge, SP is SP+1.
- R4: A two-byte push presents address SP in its first cycle and SP-1 in the second. `busy_o` is 1 during the second cycle only. SP ends lower by 2.
- R5: A two-byte pop presents address SP+1 in its first cycle and SP+2 in the second. `busy_o` is 1 during the second cycle only. SP ends higher by 2.
- R6: Strobes that arrive while `busy_o`=1 have no effect. When several strobes arrive together, priority runs two-byte push, then two-byte pop, then byte push, then byte pop.
- R7: An I/O write loads `io_wdata_i` into the high byte when `io_hi_sel_i`=1 and into the low byte when it is 0. The write wins over any stack command in the same cycle. That command, or a pending second cycle, is dropped and `mem_valid_o` stays 0.
- R8: Pointer bits at and above `SP_BITS` (default 11) always read 0 and ignore writes. Pointer arithmetic wraps modulo 2^`SP_BITS`. For example, a push at 0 leaves 0x7FF, and a pop at 0x7FF presents address 0.
- R9: `sp_next_o` equals the pointer value that the read ports show after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_byte_i | input | 1 | Single-byte push strobe |
| pop_byte_i | input | 1 | Single-byte pop strobe |
| push_ret_i | input | 1 | Two-byte (return address) push strobe |
| pop_ret_i | input | 1 | Two-byte (return address) pop strobe |
| io_we_i | input | 1 | I/O write strobe for a pointer byte |
| io_hi_sel_i | input | 1 | 1 selects the high byte, 0 the low byte |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_lo_o | output | 8 | Low pointer byte |
| io_rdata_hi_o | output | 8 | High pointer byte (zero when absent) |
| mem_addr_o | output | 16 | Stack memory byte address for this cycle |
| mem_valid_o | output | 1 | A stack access takes place this cycle |
| mem_write_o | output | 1 | 1 for a push access, 0 for a pop access |
| sp_next_o | output | 16 | Pointer value after the next edge |
| busy_o | output | 1 | Second cycle of a two-byte command in progress |

## Verification
On every cycle, the assertions check the following:

- each single step moves the pointer by exactly one, modulo the implemented width;
- an I/O write lands in the selected byte and leaves the other byte unchanged;
- a started two-byte command always brings exactly one busy cycle;
- unimplemented bits stay zero.

Only the bench scenarios can show the rest:

- the address sequences of the two-byte commands;
- the priority among simultaneous strobes;
- the dropping of strobes during the busy cycle;
- the cancelling of a pending second cycle by an I/O write;
- wrap-around at both ends of the pointer range.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_DN   = 2'd1,
    STEP_UP   = 2'd2
  } step_e;

  localparam int unsigned SP_W = 16;
endpackage

// File: rtl/sp_cmd_decode.sv
module sp_cmd_decode
  import sp_pkg::*;
(
  input  logic  push_byte,
  input  logic  pop_byte,
  input  logic  push_ret,
  input  logic  pop_ret,
  input  logic  busy,
  input  logic  pend_push,
  output step_e step,
  output logic  start_two,
  output logic  two_push
);
  // fixed priority: return push, return pop, byte push, byte pop
  always_comb begin
    step      = STEP_NONE;
    start_two = 1'b0;
    two_push  = 1'b0;
    if (busy) begin
      step = pend_push ? STEP_DN : STEP_UP;
    end else if (push_ret) begin
      step      = STEP_DN;
      start_two = 1'b1;
      two_push  = 1'b1;
    end else if (pop_ret) begin
      step      = STEP_UP;
      start_two = 1'b1;
    end else if (push_byte) begin
      step = STEP_DN;
    end else if (pop_byte) begin
      step = STEP_UP;
    end
  end
endmodule

// File: rtl/sp_seq.sv
module sp_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_two,
  input  logic two_push,
  input  logic io_we,
  output logic busy,
  output logic pend_push
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend_push <= 1'b0;
    end else if (io_we) begin
      busy      <= 1'b0;
    end else if (start_two) begin
      busy      <= 1'b1;
      pend_push <= two_push;
    end else begin
      busy      <= 1'b0;
    end
  end

  // R4 R5
  // R4
  second_phase_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_two && !io_we) |=> busy);
  // R5
  single_busy_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: rtl/sp_reg.sv
module sp_reg
  import sp_pkg::*;
#(
  parameter int unsigned SP_BITS = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  step_e           step,
  input  logic            io_we,
  input  logic            io_hi_sel,
  input  logic [7:0]      io_wdata,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_n,
  output logic [SP_W-1:0] addr
);
  localparam logic [SP_W-1:0] MASK = SP_W'((32'd1 << SP_BITS) - 32'd1);

  logic [SP_W-1:0] raw_n;
  logic [SP_W-1:0] sp_inc;

  assign sp_inc = (sp_q + 16'd1) & MASK;

  always_comb begin
    raw_n = sp_q;
    if (io_we) begin
      if (io_hi_sel) raw_n[15:8] = io_wdata;
      else           raw_n[7:0]  = io_wdata;
    end else begin
      case (step)
        STEP_DN: raw_n = sp_q - 16'd1;
        STEP_UP: raw_n = sp_q + 16'd1;
        default: raw_n = sp_q;
      endcase
    end
    sp_n = raw_n & MASK;
  end

  // post-decrement push, pre-increment pop
  assign addr = (step == STEP_UP) ? sp_inc : sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_n;
  end

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_DN && !io_we) |=> sp_q == (($past(sp_q) - 16'd1) & MASK));
  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_UP && !io_we) |=> sp_q == (($past(sp_q) + 16'd1) & MASK));
  // R7
  io_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_hi_sel) |=>
      (sp_q[15:8] == ($past(io_wdata) & MASK[15:8])) && (sp_q[7:0] == $past(sp_q[7:0])));
  // R7
  io_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !io_hi_sel) |=>
      (sp_q[7:0] == ($past(io_wdata) & MASK[7:0])) && (sp_q[15:8] == $past(sp_q[15:8])));
  // R8
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_q & ~MASK) == '0);
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int unsigned SP_BITS = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_byte_i,
  input  logic        pop_byte_i,
  input  logic        push_ret_i,
  input  logic        pop_ret_i,
  input  logic        io_we_i,
  input  logic        io_hi_sel_i,
  input  logic [7:0]  io_wdata_i,
  output logic [7:0]  io_rdata_lo_o,
  output logic [7:0]  io_rdata_hi_o,
  output logic [15:0] mem_addr_o,
  output logic        mem_valid_o,
  output logic        mem_write_o,
  output logic [15:0] sp_next_o,
  output logic        busy_o
);
  step_e           step;
  logic            start_two, two_push, busy, pend_push;
  logic [SP_W-1:0] sp_q, sp_n, addr;

  sp_cmd_decode u_dec (
    .push_byte (push_byte_i),
    .pop_byte  (pop_byte_i),
    .push_ret  (push_ret_i),
    .pop_ret   (pop_ret_i),
    .busy      (busy),
    .pend_push (pend_push),
    .step      (step),
    .start_two (start_two),
    .two_push  (two_push)
  );

  sp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_two (start_two),
    .two_push  (two_push),
    .io_we     (io_we_i),
    .busy      (busy),
    .pend_push (pend_push)
  );

  sp_reg #(.SP_BITS(SP_BITS)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .io_we     (io_we_i),
    .io_hi_sel (io_hi_sel_i),
    .io_wdata  (io_wdata_i),
    .sp_q      (sp_q),
    .sp_n      (sp_n),
    .addr      (addr)
  );

  assign io_rdata_lo_o = sp_q[7:0];

  generate
    if (SP_BITS > 8) begin : g_hi_reg
      assign io_rdata_hi_o = sp_q[15:8];
    end else begin : g_hi_absent
      assign io_rdata_hi_o = 8'h00;
    end
  endgenerate

  assign mem_valid_o = (step != STEP_NONE) && !io_we_i;
  assign mem_write_o = (step == STEP_DN);
  assign mem_addr_o  = addr;
  assign sp_next_o   = sp_n;
  assign busy_o      = busy;

  // R7
  io_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_we_i |-> !mem_valid_o);
  // R6
  busy_is_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !io_we_i) |-> mem_valid_o);
endmodule

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic        hi;
    logic [7:0]  wd;
    logic [3:0]  cmd;   // {pop_ret, push_ret, pop_byte, push_byte}
    logic        valid;
    logic        wr;
    logic        busy;
    logic [15:0] addr;
    logic [15:0] sp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b0,8'h40,4'h0, 1'b0,1'b0,1'b0,16'h0000,16'h0040}, // R7 low
    '{1'b1,1'b1,8'h03,4'h0, 1'b0,1'b0,1'b0,16'h0000,16'h0340}, // R7 high
    '{1'b1,1'b1,8'hFF,4'h0, 1'b0,1'b0,1'b0,16'h0000,16'h0740}, // R8 mask
    '{1'b0,1'b0,8'h00,4'h1, 1'b1,1'b1,1'b0,16'h0740,16'h073F}, // R2
    '{1'b0,1'b0,8'h00,4'h2, 1'b1,1'b0,1'b0,16'h0740,16'h0740}, // R3
    '{1'b0,1'b0,8'h00,4'h4, 1'b1,1'b1,1'b0,16'h0740,16'h073F}, // R4 1st
    '{1'b0,1'b0,8'h00,4'h0, 1'b1,1'b1,1'b1,16'h073F,16'h073E}, // R4 2nd
    '{1'b0,1'b0,8'h00,4'h8, 1'b1,1'b0,1'b0,16'h073F,16'h073F}, // R5 1st
    '{1'b0,1'b0,8'h00,4'h0, 1'b1,1'b0,1'b1,16'h0740,16'h0740}, // R5 2nd
    '{1'b0,1'b0,8'h00,4'h6, 1'b1,1'b1,1'b0,16'h0740,16'h073F}, // R6 prio
    '{1'b0,1'b0,8'h00,4'h2, 1'b1,1'b1,1'b1,16'h073F,16'h073E}, // R6 ignored
    '{1'b1,1'b0,8'h10,4'h1, 1'b0,1'b1,1'b0,16'h0000,16'h0710}, // R7 wins
    '{1'b1,1'b1,8'h00,4'h0, 1'b0,1'b0,1'b0,16'h0000,16'h0010}, // R7
    '{1'b1,1'b0,8'h00,4'h0, 1'b0,1'b0,1'b0,16'h0000,16'h0000}, // R7
    '{1'b0,1'b0,8'h00,4'h1, 1'b1,1'b1,1'b0,16'h0000,16'h07FF}, // R8 wrap
    '{1'b0,1'b0,8'h00,4'h2, 1'b1,1'b0,1'b0,16'h0000,16'h0000}, // R8 wrap
    '{1'b0,1'b0,8'h00,4'h8, 1'b1,1'b0,1'b0,16'h0001,16'h0001}, // R5
    '{1'b0,1'b0,8'h00,4'h0, 1'b1,1'b0,1'b1,16'h0002,16'h0002}, // R5
    '{1'b0,1'b0,8'h00,4'h4, 1'b1,1'b1,1'b0,16'h0002,16'h0001}, // R4
    '{1'b1,1'b0,8'h55,4'h0, 1'b0,1'b1,1'b1,16'h0000,16'h0055}, // R7 cancel
    '{1'b0,1'b0,8'h00,4'h0, 1'b0,1'b0,1'b0,16'h0000,16'h0055}  // R7 no 2nd
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_byte, pop_byte, push_ret, pop_ret, io_we, io_hi;
  logic [7:0]  io_wd, rd_lo, rd_hi;
  logic [15:0] maddr, spn;
  logic        mvalid, mwrite, busy;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_ptr_unit #(.SP_BITS(11)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .push_byte_i(push_byte), .pop_byte_i(pop_byte),
    .push_ret_i(push_ret), .pop_ret_i(pop_ret),
    .io_we_i(io_we), .io_hi_sel_i(io_hi), .io_wdata_i(io_wd),
    .io_rdata_lo_o(rd_lo), .io_rdata_hi_o(rd_hi),
    .mem_addr_o(maddr), .mem_valid_o(mvalid), .mem_write_o(mwrite),
    .sp_next_o(spn), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    io_we = v.we; io_hi = v.hi; io_wd = v.wd;
    push_byte = v.cmd[0]; pop_byte = v.cmd[1];
    push_ret = v.cmd[2]; pop_ret = v.cmd[3];
  endtask

  initial begin
    drive('0);
    #(CLK_PERIOD*2);
    // R1 reset state
    chk("R1 sp", {rd_hi, rd_lo}, 16'h0000);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 valid", {15'd0, mvalid}, 16'd0);
    chk("R1 next", spn, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      #1;
      chk($sformatf("R2-step%0d valid", i), {15'd0, mvalid}, {15'd0, VT[i].valid});
      chk($sformatf("R6 row%0d busy", i), {15'd0, busy}, {15'd0, VT[i].busy});
      if (VT[i].valid) begin
        chk($sformatf("R4 row%0d addr", i), maddr, VT[i].addr);
        chk($sformatf("R3 row%0d dir", i), {15'd0, mwrite}, {15'd0, VT[i].wr});
      end
      chk($sformatf("R9 row%0d next", i), spn, VT[i].sp);
      @(posedge clk); #1;
      chk($sformatf("R8 row%0d sp", i), {rd_hi, rd_lo}, VT[i].sp);
    end

    // R1 reset during a pending second cycle
    @(negedge clk); drive('0); push_ret = 1'b1;
    @(negedge clk); drive('0);
    chk("R4 busy before reset", {15'd0, busy}, 16'd1);
    rst_n = 1'b0; #1;
    chk("R1 reset sp", {rd_hi, rd_lo}, 16'h0000);
    chk("R1 reset busy", {15'd0, busy}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stays idle", {15'd0, mvalid}, 16'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule